// File: doc/BRIEF.md
# Thread Run/Park Control Register

This block decides which hardware threads of a multithreaded core are allowed to run. Software writes a running mask through a simple register port, which carries a write strobe, the data and the ID of the thread making the write. Each thread whose bit is 0 receives a park request. The thread's pipeline answers with a park acknowledge once it has drained. A second, read-only status mask reports what the threads are actually doing. Each status bit changes only after that thread's pipeline has acknowledged the transition. Because of this, the status mask trails the running mask whenever a park or an unpark is still in flight.

A write that would clear every bit is not allowed to park the whole core. The block stores only the bit of the thread that issued the write, so that thread keeps running. A new write may arrive while earlier transitions are still pending. It replaces the running mask at once, and each thread's status then follows that thread's own acknowledge.

Top module: `thread_run_ctl`

## Requirements
- R1: After reset, both the running mask and the status mask read as all ones, and no park request is asserted.
- R2: A write with nonzero data stores that data in the running mask, and the new value reads back from the cycle after the write.
- R3: Each `park_req[i]` is the inverse of running bit i, and it changes only in the cycle after a write.
- R4: A write of all zeros from thread ID t stores a mask in which only bit t is set. The running mask is never all zeros.
- R5: A status bit that is 1 becomes 0 only in the cycle after `park_req[i]` and `park_ack[i]` were both high.
- R6: A status bit that is 0 becomes 1 only in the cycle after `park_req[i]` and `park_ack[i]` were both low.
- R7: Once every thread's acknowledge matches its request, the status mask equals the running mask.
- R8: A write made while a transition is pending takes effect at once in the running mask. A park that is cancelled before its acknowledge arrives leaves the status bit at 1.
- R9: `rd_data` returns the running mask when `rd_sel_run` is high. It returns the status mask when only `rd_sel_stat` is high, and zero when neither select is high.
- R10: After a park-all write from thread t has settled, the running mask and the status mask both read as only bit t set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the running mask |
| wr_data | input | N_THREADS | New running mask |
| wr_tid | input | ID_W | ID of the thread issuing the write |
| rd_sel_run | input | 1 | Select the running mask onto rd_data |
| rd_sel_stat | input | 1 | Select the status mask onto rd_data |
| rd_data | output | N_THREADS | Read data |
| park_req | output | N_THREADS | Per-thread park request |
| park_ack | input | N_THREADS | Per-thread park acknowledge from the pipelines |

## Verification
The bench builds the block with its default of eight threads and a three-bit writer ID. This allows a park-all write to be issued from a writer ID in the middle of the range and from the highest ID. Each thread's acknowledge comes from its own latency model, so transitions on different threads overlap and finish out of order. It also allows a pending park to be cancelled before its acknowledge arrives.

// File: rtl/trc_pkg.sv
package trc_pkg;
  // One-hot mask with only bit idx set; zero when idx is out of range.
  function automatic logic [255:0] trc_onehot(input int unsigned idx, input int unsigned n);
    logic [255:0] m;
    m = '0;
    if (idx < n) m[idx] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/trc_run_reg.sv
module trc_run_reg
  import trc_pkg::*;
#(
  parameter int N_THREADS = 8,
  parameter int ID_W      = $clog2(N_THREADS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [N_THREADS-1:0] wr_data,
  input  logic [ID_W-1:0]      wr_tid,
  output logic [N_THREADS-1:0] run_q
);
  logic [N_THREADS-1:0] guard_mask;
  logic [N_THREADS-1:0] run_d;
  logic                 all_clear;
  logic [255:0]         self_bit;

  // Park-all protection: substitute the writer's own bit.
  always_comb begin
    all_clear  = (wr_data == '0);
    self_bit   = trc_onehot(int'(wr_tid), N_THREADS);
    guard_mask = all_clear ? self_bit[N_THREADS-1:0] : wr_data;
    run_d      = guard_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '1;
    end else if (wr_en) begin
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/trc_thread_slot.sv
module trc_thread_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic run_bit,
  input  logic park_ack,
  output logic park_req,
  output logic stat_q
);
  logic park_done;
  logic unpark_done;
  logic stat_en;
  logic stat_d;

  always_comb begin
    park_req    = ~run_bit;
    park_done   = park_req & park_ack;
    unpark_done = ~park_req & ~park_ack;
    stat_en     = (stat_q & park_done) | (~stat_q & unpark_done);
    stat_d      = ~stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b1;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/trc_read_mux.sv
module trc_read_mux #(
  parameter int N_THREADS = 8
) (
  input  logic                 sel_run,
  input  logic                 sel_stat,
  input  logic [N_THREADS-1:0] run_mask,
  input  logic [N_THREADS-1:0] stat_mask,
  output logic [N_THREADS-1:0] rd_data
);
  always_comb begin
    if (sel_run)       rd_data = run_mask;
    else if (sel_stat) rd_data = stat_mask;
    else               rd_data = '0;
  end
endmodule

// File: rtl/thread_run_ctl.sv
module thread_run_ctl #(
  parameter int N_THREADS = 8,
  parameter int ID_W      = $clog2(N_THREADS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [N_THREADS-1:0] wr_data,
  input  logic [ID_W-1:0]      wr_tid,
  input  logic                 rd_sel_run,
  input  logic                 rd_sel_stat,
  output logic [N_THREADS-1:0] rd_data,
  output logic [N_THREADS-1:0] park_req,
  input  logic [N_THREADS-1:0] park_ack
);
  logic                 rst_meta_n;
  logic                 rst_sync_n;
  logic [N_THREADS-1:0] run_q;
  logic [N_THREADS-1:0] stat_q;

  // Asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  trc_run_reg #(.N_THREADS(N_THREADS), .ID_W(ID_W)) u_run (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_tid  (wr_tid),
    .run_q   (run_q)
  );

  for (genvar g = 0; g < N_THREADS; g++) begin : g_slot
    trc_thread_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .run_bit  (run_q[g]),
      .park_ack (park_ack[g]),
      .park_req (park_req[g]),
      .stat_q   (stat_q[g])
    );
  end

  trc_read_mux #(.N_THREADS(N_THREADS)) u_rd (
    .sel_run   (rd_sel_run),
    .sel_stat  (rd_sel_stat),
    .run_mask  (run_q),
    .stat_mask (stat_q),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int N_THREADS = 8,
  parameter int ID_W      = $clog2(N_THREADS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [N_THREADS-1:0] wr_data,
  input logic [ID_W-1:0]      wr_tid,
  input logic                 rd_sel_run,
  input logic                 rd_sel_stat,
  input logic [N_THREADS-1:0] rd_data,
  input logic [N_THREADS-1:0] park_req,
  input logic [N_THREADS-1:0] park_ack,
  input logic [N_THREADS-1:0] stat_q
);
  AST_WRITE_DRIVES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data != '0) |=> (park_req == ~$past(wr_data))); // R2
  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(park_req)); // R3
  AST_PARK_ALL_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == '0) |=> ($countones(park_req) == N_THREADS - 1 && !park_req[$past(wr_tid)])); // R4
  AST_NEVER_ALL_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    park_req != '1); // R4
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_sel_run && !rd_sel_stat) |-> rd_data == '0); // R9

  for (genvar g = 0; g < N_THREADS; g++) begin : g_chk
    AST_STAT_CLEAR_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[g] && !(park_req[g] && park_ack[g])) |=> stat_q[g]); // R5
    AST_STAT_SET_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[g] && !(!park_req[g] && !park_ack[g])) |=> !stat_q[g]); // R6
  end
endmodule

bind thread_run_ctl trc_checker #(.N_THREADS(N_THREADS), .ID_W(ID_W)) u_trc_checker (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .wr_tid      (wr_tid),
  .rd_sel_run  (rd_sel_run),
  .rd_sel_stat (rd_sel_stat),
  .rd_data     (rd_data),
  .park_req    (park_req),
  .park_ack    (park_ack),
  .stat_q      (stat_q)
);

// File: tb/thread_run_ctl_bench.sv
`timescale 1ns/1ps
module thread_run_ctl_bench;
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [N-1:0] wr_data = '0;
  logic [IW-1:0] wr_tid = '0;
  logic         rd_sel_run = 1'b0;
  logic         rd_sel_stat = 1'b0;
  logic [N-1:0] rd_data;
  logic [N-1:0] park_req;
  logic [N-1:0] park_ack = '0;

  int checks = 0;
  int fails  = 0;
  int lat [N];
  int cnt [N];
  bit done = 1'b0;

  logic [N-1:0] run_m;
  logic [N-1:0] stat_m;

  always #5 clk = ~clk;

  thread_run_ctl #(.N_THREADS(N)) u_thread_run_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_tid(wr_tid),
    .rd_sel_run(rd_sel_run), .rd_sel_stat(rd_sel_stat), .rd_data(rd_data),
    .park_req(park_req), .park_ack(park_ack)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference, updated on the same edges as the design.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_m  <= '1;
      stat_m <= '1;
    end else begin
      if (wr_en) run_m <= (wr_data == 0) ? N'(1 << wr_tid) : wr_data;
      for (int i = 0; i < N; i++) begin
        if (!run_m[i] && park_ack[i]) stat_m[i] <= 1'b0;
        else if (run_m[i] && !park_ack[i]) stat_m[i] <= 1'b1;
      end
    end
  end

  // Per-clock comparison, away from the edge.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R3", park_req, ~run_m);
      check("R9", rd_data, rd_sel_run ? run_m : (rd_sel_stat ? stat_m : '0));
    end
  end

  // Pipeline model: acknowledge follows request after a per-thread latency.
  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        park_ack[i] = 1'b0; cnt[i] = 0;
      end else if (park_ack[i] != park_req[i]) begin
        cnt[i]++;
        if (cnt[i] >= lat[i]) begin park_ack[i] = park_req[i]; cnt[i] = 0; end
      end else cnt[i] = 0;
    end
  end

  task automatic write(input logic [N-1:0] d, input int tid);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_tid = IW'(tid);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read(input bit run_s, input bit stat_s, output logic [N-1:0] v);
    rd_sel_run = run_s; rd_sel_stat = stat_s;
    #1 v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<=100000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) begin lat[i] = 3 + i; cnt[i] = 0; end
    idle(3);
    rst_n = 1'b1;
    idle(4);

    read(1, 0, v); check("R1 run after reset", v, '1);
    read(0, 1, v); check("R1 status after reset", v, '1);
    check("R1 park_req after reset", park_req, '0);

    write(8'hF0, 0);
    read(1, 0, v); check("R2 run readback", v, 8'hF0);
    read(0, 1, v); check("R5 status lags write", v, 8'hFF);
    idle(20);
    read(0, 1, v); check("R7 status settled", v, 8'hF0);

    write(8'h00, 3);
    read(1, 0, v); check("R4 park-all keeps writer", v, 8'h08);
    idle(30);
    read(1, 0, v); check("R10 run after park-all", v, 8'h08);
    read(0, 1, v); check("R10 status after park-all", v, 8'h08);

    write(8'hFF, 3);
    idle(30);
    read(0, 1, v); check("R6 unpark restores status", v, 8'hFF);

    write(8'h00, 7);
    idle(30);
    read(0, 1, v); check("R10 park-all from top ID", v, 8'h80);
    write(8'hFF, 7);
    idle(30);

    lat[2] = 12;
    write(8'hFB, 1);
    idle(3);
    read(0, 1, v); check("R5 pending park keeps status", v, 8'hFF);
    write(8'hFF, 1);
    read(1, 0, v); check("R8 write during pending", v, 8'hFF);
    idle(20);
    read(0, 1, v); check("R8 cancelled park status", v, 8'hFF);
    lat[2] = 5;

    read(1, 1, v); check("R9 run has priority", v, 8'hFF);
    read(0, 0, v); check("R9 idle read zero", v, 8'h00);

    for (int k = 0; k < 400; k++) begin
      for (int i = 0; i < N; i++) lat[i] = int'($urandom_range(1, 15));
      write(($urandom_range(0, 4) == 0) ? 8'h00 : N'($urandom), int'($urandom_range(0, N - 1)));
      rd_sel_run = $urandom_range(0, 1); rd_sel_stat = $urandom_range(0, 1);
      idle(int'($urandom_range(0, 12)));
    end

    write(8'h5A, 2);
    idle(40);
    read(0, 1, v); check("R7 final status", v, 8'h5A);
    read(1, 0, v); check("R7 final run", v, 8'h5A);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule